// File: doc/BRIEF.md
# Serial-Peripheral EEPROM Slave Model

This block models the device side of a small serial EEPROM of 256 bytes that answers on a four-wire serial bus in mode 0. The host selects the part with an active-low select and sends bits most-significant first on the data-in line. The block samples a bit on each rising serial clock and shifts read data out on each falling serial clock. Every command starts with an 8-bit instruction. Reads and writes then take an 8-bit byte address. A read streams bytes for as long as the host keeps clocking. A write first needs a separate enable command, and it is committed to the array only when select rises on a legal clock count.

All logic runs in one system clock domain. The serial clock, select, data-in and pause inputs are synchronized, and their edges are detected there. The serial clock must therefore run well below the system clock: each serial half period needs at least four system cycles. Data moves over the serial pins, which have no back-pressure. The host may stop a transfer for a while with the active-low pause input, and the block then neither counts nor drives. The output enable tells the pad when the data-out line should be driven. At all other times the pin is meant to float.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Bits on `si` are taken on rising `sck` edges, MSB first. `so` changes only after falling `sck` edges, so the host can sample it on the next rising edge.
- R2: Opcode 0x03 followed by address A streams out the bytes at A, A+1, A+2 and so on, starting at the 16th falling edge. The address wraps from 0xFF to 0x00, and the stream ends when `cs_n` goes high.
- R3: Opcode 0x06 sets the write-enable latch only when `cs_n` rises after exactly 8 clocks. If more clocks follow the opcode, the latch is left unchanged.
- R4: Opcode 0x02 changes no memory byte while the write-enable latch is clear.
- R5: Write data bytes land at the given address and then at the next ones. Only address bits [1:0] advance and bits [7:2] stay fixed, so writing past the last byte of a 4-byte page wraps to its first byte and overwrites it.
- R6: A write is committed only if `cs_n` rises after exactly 24, 32, 40 or 48 clocks. At any other count the whole write is discarded and the latch is kept.
- R7: A committed write clears the write-enable latch.
- R8: Pulling `hold_n` low while `sck` is low pauses the transfer. Clock edges are then ignored and `so_oe` is low. Raising `hold_n` while `sck` is low resumes the transfer from the bit where it stopped.
- R9: `so_oe` is high only in the data phase of a read, while selected and not paused. An unknown opcode drives nothing and changes nothing until `cs_n` goes high.
- R10: A rising `sck` edge that arrives in the same synchronized cycle as `cs_n` rising is not counted.
- R11: After reset every byte reads 0xFF, the latch is clear and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` |

## Verification
Deselect and the serial clock edge can reach the controller in the same synchronized cycle. In that cycle both commit and counting want to act. The bench provokes this by raising `cs_n` and the 24th `sck` edge at the same instant during a write. It then reads the address back and expects the old value, because that edge was not counted. A normal 24-clock write to the same address then proves that the latch survived the discarded attempt.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int         W      = 4,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[s] <= RST;
      else if (s == 0) stg[s] <= d;
      else             stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int         ADDR_W   = 8,
  parameter int         PAGE_W   = 2,
  parameter logic [7:0] ERASED   = 8'hFF,
  localparam int        DEPTH    = 1 << ADDR_W,
  localparam int        PB       = 1 << PAGE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_data,
  input  logic [PB-1:0]              we,
  input  logic [ADDR_W-PAGE_W-1:0]   wr_page,
  input  logic [PB-1:0][7:0]         wr_data
);
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= ERASED;
    end else begin
      for (int l = 0; l < PB; l++)
        if (we[l]) arr[{wr_page, PAGE_W'(l)}] <= wr_data[l];
    end
  end

  assign rd_data = arr[rd_addr];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int  ADDR_W = 8,
  parameter int  PAGE_W = 2,
  localparam int PB     = 1 << PAGE_W,
  localparam int PG_W   = ADDR_W - PAGE_W,
  localparam int BC_W   = $clog2(PB + 4),
  localparam logic [BC_W-1:0] BC_MAX  = '1,
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(PB + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck_s,
  input  logic                 cs_n_s,
  input  logic                 hold_n_s,
  input  logic                 si_s,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic [7:0]           rd_data,
  output logic [PB-1:0]        mem_we,
  output logic [PG_W-1:0]      mem_page,
  output logic [PB-1:0][7:0]   mem_wdata,
  output logic                 so,
  output logic                 so_oe
);
  logic sck_p, cs_p, hold_p;
  logic sck_rise, sck_fall, cs_rise, hold_fall, hold_rise;
  logic [2:0]        bitcnt;
  logic [BC_W-1:0]   bytecnt;
  logic [7:0]        sr, op, out_sr, new_byte;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]   page_q;
  logic [PB-1:0]     mask, lane_wr;
  logic [7:0]        pbuf [PB];
  logic              wel, held, rd_act, so_q;
  logic              sck_go, byte_done, data_wr, commit, wren_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 1'b0; cs_p <= 1'b1; hold_p <= 1'b1;
    end else begin
      sck_p <= sck_s; cs_p <= cs_n_s; hold_p <= hold_n_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_p;
  assign sck_fall  = ~sck_s & sck_p;
  assign cs_rise   = cs_n_s & ~cs_p;
  assign hold_fall = ~hold_n_s & hold_p;
  assign hold_rise = hold_n_s & ~hold_p;

  // a rising edge together with deselect is dropped: cs_n_s is already high
  assign sck_go    = sck_rise & ~cs_n_s & ~held;
  assign byte_done = sck_go & (bitcnt == 3'd7);
  assign new_byte  = {sr[6:0], si_s};
  assign data_wr   = byte_done & (op == OP_WRITE) & (bytecnt >= BC_W'(2));
  assign rd_addr   = (bytecnt == BC_W'(1)) ? new_byte[ADDR_W-1:0] : addr_q + 1'b1;

  assign commit  = cs_rise & (op == OP_WRITE) & wel & (bitcnt == 3'd0) &
                   (bytecnt >= BC_W'(3)) & (bytecnt <= BC_LAST);
  assign wren_ok = cs_rise & (op == OP_WREN) & (bitcnt == 3'd0) &
                   (bytecnt == BC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0; bytecnt <= '0; sr <= '0; op <= '0; out_sr <= '0;
      addr_q <= '0; page_q <= '0; mask <= '0; wel <= 1'b0;
      held <= 1'b0; rd_act <= 1'b0; so_q <= 1'b0;
    end else if (cs_n_s) begin
      if (commit)       wel <= 1'b0;
      else if (wren_ok) wel <= 1'b1;
      bitcnt <= '0; bytecnt <= '0; op <= '0; mask <= '0;
      held <= 1'b0; rd_act <= 1'b0;
    end else begin
      if (hold_fall && !sck_s)      held <= 1'b1;
      else if (hold_rise && !sck_s) held <= 1'b0;
      if (sck_go) begin
        sr     <= new_byte;
        bitcnt <= bitcnt + 3'd1;
        if (byte_done) begin
          if (bytecnt != BC_MAX) bytecnt <= bytecnt + 1'b1;
          if (bytecnt == '0) op <= new_byte;
          if (bytecnt == BC_W'(1)) begin
            addr_q <= new_byte[ADDR_W-1:0];
            page_q <= new_byte[ADDR_W-1:PAGE_W];
          end
          if (bytecnt != '0 && op == OP_READ) begin
            addr_q <= rd_addr;
            out_sr <= rd_data;
            rd_act <= 1'b1;
          end
          if (data_wr) begin
            mask <= mask | lane_wr;
            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
          end
        end
      end
      if (sck_fall && rd_act && !held) begin
        so_q   <= out_sr[7];
        out_sr <= {out_sr[6:0], 1'b0};
      end
    end
  end

  for (genvar l = 0; l < PB; l++) begin : g_lane
    assign lane_wr[l] = data_wr & (addr_q[PAGE_W-1:0] == PAGE_W'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pbuf[l] <= '0;
      else if (lane_wr[l]) pbuf[l] <= new_byte;
    end
    assign mem_wdata[l] = pbuf[l];
  end

  assign mem_we   = commit ? mask : '0;
  assign mem_page = page_q;
  assign so       = so_q;
  assign so_oe    = rd_act & ~held & ~cs_n_s;

  a_r4_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> wel);
  a_r7_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |=> !wel);
  a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_n_s) |=> ($stable(bitcnt) && $stable(bytecnt)));
  a_r9_so_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !so_oe);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ERASED      = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int PB   = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [3:0]              pins_s;
  logic [ADDR_W-1:0]       rd_addr;
  logic [7:0]              rd_data;
  logic [PB-1:0]           mem_we;
  logic [PG_W-1:0]         mem_page;
  logic [PB-1:0][7:0]      mem_wdata;

  spi_ee_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hold_n, cs_n, sck, si}), .q(pins_s));

  spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[1]), .cs_n_s(pins_s[2]), .hold_n_s(pins_s[3]), .si_s(pins_s[0]),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .mem_we(mem_we), .mem_page(mem_page), .mem_wdata(mem_wdata),
    .so(so), .so_oe(so_oe));

  spi_ee_mem #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ERASED(ERASED)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .we(mem_we), .wr_page(mem_page), .wr_data(mem_wdata));
endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] wdat [8];
  bit   wel_m = 1'b0;
  bit   rd_cap = 1'b0;
  logic [7:0] cap = '0;
  int   ncap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_slave dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .si(si), .hold_n(hold_n), .so(so), .so_oe(so_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_hp(input int n = 1);
    repeat (n * HP) @(negedge clk);
  endtask

  task automatic bit_x(input logic b);
    si = b; wait_hp(); sck = 1'b1; wait_hp(); sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_x(b[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_hp();
  endtask

  task automatic desel();
    wait_hp(); cs_n = 1'b1; wait_hp(4);
  endtask

  task automatic wren();
    sel(); send_byte(8'h06); desel(); wel_m = 1'b1;
  endtask

  // driver: pushes expected read bytes, monitor compares them
  task automatic spi_read(input logic [7:0] a, input int n, input string req);
    sel(); send_byte(8'h03); send_byte(a);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_mem[8'(a + i)]); tag_q.push_back(req);
    end
    rd_cap = 1'b1;
    for (int i = 0; i < n; i++) send_byte(8'h00);
    rd_cap = 1'b0;
    desel();
  endtask

  task automatic spi_write(input logic [7:0] a, input int n, input int extra);
    logic [7:0] ad;
    sel(); send_byte(8'h02); send_byte(a);
    for (int i = 0; i < n; i++) send_byte(wdat[i]);
    for (int i = 0; i < extra; i++) bit_x(1'b1);
    desel();
    if (wel_m && extra == 0 && n >= 1 && n <= 4) begin
      ad = a;
      for (int i = 0; i < n; i++) begin
        ref_mem[ad] = wdat[i];
        ad[1:0] = ad[1:0] + 2'd1;
      end
      wel_m = 1'b0;
    end
  endtask

  always @(posedge sck) begin
    if (rd_cap) begin
      cap = {cap[6:0], so};
      ncap++;
      if (ncap == 8) begin
        ncap = 0;
        if (exp_q.size() == 0) chk(1'b0, "R2 extra byte", cap, 0);
        else begin
          string t;
          logic [7:0] e;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(cap == e, t, cap, e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(so_oe == 1'b0, "R11 so_oe after reset", so_oe, 0);
    spi_read(8'h00, 2, "R11 erased read");

    // R1 R3 R6: single byte write, 24 clocks
    wren(); wdat[0] = 8'hA5; spi_write(8'h20, 1, 0);
    spi_read(8'h20, 1, "R1 R6 byte write 24 clocks");

    // R7 R4: latch cleared, second write ignored
    wdat[0] = 8'h5A; spi_write(8'h21, 1, 0);
    spi_read(8'h20, 2, "R4 R7 write without latch");

    // R3: WREN followed by more clocks is ignored
    sel(); send_byte(8'h06); send_byte(8'h00); desel();
    wdat[0] = 8'h11; spi_write(8'h30, 1, 0);
    spi_read(8'h30, 1, "R3 long wren ignored");

    // R5: four bytes from 0x12 wrap inside page 0x10..0x13
    wren(); wdat[0] = 8'h01; wdat[1] = 8'h02; wdat[2] = 8'h03; wdat[3] = 8'h04;
    spi_write(8'h12, 4, 0);
    spi_read(8'h10, 4, "R5 page wrap 48 clocks");

    // R6: illegal counts discard, latch kept
    wren(); wdat[0] = 8'hE1; wdat[1] = 8'hE2; spi_write(8'h40, 2, 4);
    spi_read(8'h40, 1, "R6 36 clocks discarded");
    for (int i = 0; i < 5; i++) wdat[i] = 8'h90 + 8'(i);
    spi_write(8'h41, 5, 0);
    spi_read(8'h40, 2, "R6 56 clocks discarded");
    wdat[0] = 8'hB0; wdat[1] = 8'hB1; wdat[2] = 8'hB2;
    spi_write(8'h44, 3, 0);
    spi_read(8'h44, 3, "R6 40 clocks after discards");

    // R2: read wraps 0xFF to 0x00
    wren(); wdat[0] = 8'hC1; wdat[1] = 8'hC2; spi_write(8'hFE, 2, 0);
    spi_read(8'hFE, 4, "R2 address wrap");

    // R8: hold in the middle of a read
    sel(); send_byte(8'h03); send_byte(8'h10);
    exp_q.push_back(ref_mem[8'h10]); tag_q.push_back("R8 read across hold");
    exp_q.push_back(ref_mem[8'h11]); tag_q.push_back("R8 read after hold");
    rd_cap = 1'b1;
    for (int i = 0; i < 3; i++) bit_x(1'b0);
    chk(so_oe == 1'b1, "R9 so_oe in read data", so_oe, 1);
    hold_n = 1'b0; wait_hp(2);
    chk(so_oe == 1'b0, "R8 so_oe off while held", so_oe, 0);
    rd_cap = 1'b0;
    for (int i = 0; i < 3; i++) bit_x(1'b1);
    hold_n = 1'b1; wait_hp();
    rd_cap = 1'b1;
    for (int i = 0; i < 13; i++) bit_x(1'b0);
    rd_cap = 1'b0;
    desel();

    // R9: unknown opcode drives nothing, changes nothing
    sel(); send_byte(8'h05); send_byte(8'h10); send_byte(8'h77);
    chk(so_oe == 1'b0, "R9 unknown opcode so_oe", so_oe, 0);
    desel();
    spi_read(8'h10, 1, "R9 unknown opcode no change");

    // R10: 24th rising edge coincides with deselect -> not counted
    wren();
    sel(); send_byte(8'h02); send_byte(8'h50);
    for (int i = 7; i >= 1; i--) bit_x(1'b0);
    si = 1'b1; wait_hp(); sck = 1'b1; cs_n = 1'b1; wait_hp(); sck = 1'b0; wait_hp(4);
    spi_read(8'h50, 1, "R10 coincident edge dropped");
    wdat[0] = 8'h66; spi_write(8'h50, 1, 0);
    spi_read(8'h50, 1, "R10 latch kept after drop");

    chk(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule